// File: doc/BRIEF.md
# Keyboard Matrix Read Port

This block lets an 8-bit CPU read an 8x8 key-state matrix as ordinary memory. Every clock edge it copies the key states from an external debounced source into a register. A read strobe whose address falls inside the keyboard window raises a select flag. While that flag is high, the block drives one data byte, and a data-bus mux can route that byte to the CPU.

The low address byte is a row bitmask and not a row index. Address bit n picks matrix row n. The byte returned is the bitwise OR of every picked row, so one read can test several rows at once. Within a row, bit k reports key k, and a pressed key reads as 1. Some rows have positions with no key behind them. Those positions always read 0. The right-shift and control positions in the modifier row can each be switched on or off with a parameter.

Top module: `kbd_matrix_reader`

## Requirements
- R1: `sel_o` is 1 exactly when `rd_i` is 1 and `addr_i` is in the range 3800h to 3BFFh inclusive. It is 0 for every other combination.
- R2: `data_o` is 00h whenever `sel_o` is 0.
- R3: When the low address byte has only bit n set, `data_o` bit k equals the sampled key at row n, column k. That key is `keys_i[8*n+k]`, and a pressed key is 1.
- R4: When several bits of the low address byte are set, `data_o` is the bitwise OR of all the picked rows after masking.
- R5: A selected read whose low address byte is 00h returns 00h.
- R6: The range 3900h to 3BFFh mirrors 3800h to 38FFh. A read returns the same byte as the address with the same low byte in the 38xxh page.
- R7: Row 3 bits 3 to 7 always read 0. Row 7 bits 2, 3, 5, 6 and 7 always read 0. Row 7 bit 1 (right shift) reads its key only when `RSHIFT_EN`=1, and row 7 bit 4 (control) reads its key only when `CTRL_EN`=1. Both parameters default to 1.
- R8: Reads use the key state captured at the most recent rising clock edge. A change on `keys_i` between edges does not reach `data_o` until the next edge.
- R9: While `rst_ni` is low the captured matrix is all zeros, so a selected read returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | Memory read strobe, active high |
| keys_i | input | 64 | Debounced key states; bit 8*row+col, 1 = pressed |
| data_o | output | 8 | Read data; 00h when not selected |
| sel_o | output | 1 | Chip select for the data-bus mux |

## Verification
The bench targets the window edges 37FFh, 3800h, 3BFFh and 3C00h. A decoder with an off-by-one limit, or one that ignores bits 10 and 11, would select a neighbouring region or miss the mirror. It uses reads with several row bits set and reads with a zero low byte. A decoder that treats the low byte as an index, or that returns the last row it saw, would give a wrong byte on these reads. It holds every key pressed to expose unused positions that leak through, and it changes the keys between clock edges. A design that feeds `keys_i` straight to the output would show the new value too early.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KBD_ROWS = 8;
  localparam int KBD_COLS = 8;
  localparam int KBD_KEYS = KBD_ROWS * KBD_COLS;

  typedef logic [KBD_COLS-1:0] kbd_row_t;

  // populated key positions per row
  function automatic kbd_row_t row_mask(int row, bit rshift_en, bit ctrl_en);
    kbd_row_t m;
    case (row)
      3:       m = 8'h07;
      7:       m = 8'h01 | (rshift_en ? 8'h02 : 8'h00) | (ctrl_en ? 8'h10 : 8'h00);
      default: m = 8'hFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/kbd_window_decode.sv
module kbd_window_decode #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h3800,
  parameter logic [ADDR_W-1:0] WIN_LAST = 16'h3BFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  output logic              hit_o
);
  logic above_base, below_last;
  assign above_base = (addr_i >= WIN_BASE);
  assign below_last = (addr_i <= WIN_LAST);
  assign hit_o      = rd_i & above_base & below_last;
endmodule

// File: rtl/kbd_matrix_sample.sv
module kbd_matrix_sample import kbd_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [KBD_KEYS-1:0] keys_i,
  output logic [KBD_KEYS-1:0] mat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mat_o <= '0;
    else         mat_o <= keys_i;
  end
endmodule

// File: rtl/kbd_row_merge.sv
module kbd_row_merge import kbd_pkg::*; #(
  parameter bit RSHIFT_EN = 1'b1,
  parameter bit CTRL_EN   = 1'b1
) (
  input  logic [KBD_KEYS-1:0] mat_i,
  input  logic [KBD_ROWS-1:0] row_sel_i,
  output kbd_row_t            data_o
);
  kbd_row_t masked [KBD_ROWS];

  for (genvar r = 0; r < KBD_ROWS; r++) begin : g_row
    localparam kbd_row_t MASK = row_mask(r, RSHIFT_EN, CTRL_EN);
    assign masked[r] = mat_i[r*KBD_COLS +: KBD_COLS] & MASK & {KBD_COLS{row_sel_i[r]}};
  end

  always_comb begin
    data_o = '0;
    for (int r = 0; r < KBD_ROWS; r++) data_o |= masked[r];
  end
endmodule

// File: rtl/kbd_matrix_reader.sv
module kbd_matrix_reader import kbd_pkg::*; #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h3800,
  parameter logic [ADDR_W-1:0] WIN_LAST  = 16'h3BFF,
  parameter bit                RSHIFT_EN = 1'b1,
  parameter bit                CTRL_EN   = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic [KBD_KEYS-1:0] keys_i,
  output logic [KBD_COLS-1:0] data_o,
  output logic                sel_o
);
  logic [KBD_KEYS-1:0] mat_q;
  kbd_row_t            merged;

  kbd_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .hit_o(sel_o)
  );

  kbd_matrix_sample u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .keys_i(keys_i), .mat_o(mat_q)
  );

  kbd_row_merge #(.RSHIFT_EN(RSHIFT_EN), .CTRL_EN(CTRL_EN)) u_mrg (
    .mat_i(mat_q), .row_sel_i(addr_i[KBD_ROWS-1:0]), .data_o(merged)
  );

  assign data_o = sel_o ? merged : '0;

  assert_sel_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> (rd_i && addr_i[15:10] == 6'b001110));
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> data_o == '0);
  assert_zero_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && addr_i[7:0] == 8'h00) |-> data_o == '0);
  assert_row0_cover_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && addr_i[0]) |-> ((data_o & mat_q[7:0]) == mat_q[7:0]));
  assert_unused_row3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && addr_i[7:0] == 8'h08) |-> data_o[7:3] == 5'b0);
  assert_unused_row7_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && addr_i[7:0] == 8'h80) |-> (data_o & 8'hEC) == 8'h00);
endmodule

// File: tb/kbd_matrix_reader_tb_top.sv
module kbd_matrix_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic [63:0] keys = '0;
  logic [7:0]  data;
  logic        sel;
  int total = 0, bad = 0;
  logic [63:0] samp = '0;

  always #5 clk = ~clk;

  kbd_matrix_reader dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd),
    .keys_i(keys), .data_o(data), .sel_o(sel)
  );

  function automatic logic [7:0] mask_of(int r);
    if (r == 3) return 8'h07;
    if (r == 7) return 8'h13;
    return 8'hFF;
  endfunction

  function automatic logic exp_sel(logic [15:0] a, logic r);
    return r && a >= 16'h3800 && a <= 16'h3BFF;
  endfunction

  function automatic logic [7:0] exp_data(logic [63:0] k, logic [15:0] a, logic r);
    logic [7:0] d = '0;
    if (!exp_sel(a, r)) return '0;
    for (int i = 0; i < 8; i++) if (a[i]) d |= k[i*8 +: 8] & mask_of(i);
    return d;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  // load keys, capture on an edge, then read
  task automatic load(logic [63:0] k);
    @(negedge clk); keys = k;
    @(posedge clk); samp = k;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic r);
    @(negedge clk); addr = a; rd = r;
    #1;
    chk({req, "_sel"}, {7'b0, sel}, {7'b0, exp_sel(a, r)});
    chk(req, data, exp_data(samp, a, r));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    keys = '1; addr = 16'h38FF; rd = 1'b1;
    #23;
    chk("R9 reset", data, 8'h00);
    @(negedge clk); rst_ni = 1'b1; rd = 1'b0;

    load(64'h0123_4567_89AB_CDEF);
    rd_chk("R1 below", 16'h37FF, 1'b1);
    rd_chk("R1 base", 16'h3800, 1'b1);
    rd_chk("R1 last", 16'h3BFF, 1'b1);
    rd_chk("R1 above", 16'h3C00, 1'b1);
    rd_chk("R2 no_rd", 16'h3801, 1'b0);
    rd_chk("R5 zero", 16'h3800, 1'b1);
    rd_chk("R5 zero_mirror", 16'h3A00, 1'b1);
    for (int r = 0; r < 8; r++) rd_chk("R3 row", 16'h3800 | (16'h1 << r), 1'b1);
    rd_chk("R4 multi", 16'h380A, 1'b1);
    rd_chk("R4 all", 16'h38FF, 1'b1);
    rd_chk("R6 mirror39", 16'h3904, 1'b1);
    rd_chk("R6 mirror3b", 16'h3B81, 1'b1);

    load('1);
    rd_chk("R7 row3", 16'h3808, 1'b1);
    rd_chk("R7 row7", 16'h3880, 1'b1);
    chk("R7 row7 val", data, 8'h13);

    // R8: change between edges must not show until next edge
    load(64'h0000_0000_0000_0055);
    rd_chk("R8 before", 16'h3801, 1'b1);
    keys = 64'h0000_0000_0000_00AA;
    #1;
    chk("R8 hold", data, 8'h55);
    @(posedge clk); #1;
    chk("R8 update", data, 8'hAA);
    samp = keys;

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      load({$urandom, $urandom});
      case ($urandom_range(0, 3))
        0: a = 16'(16'h3800 + $urandom_range(0, 16'h3FF));
        1: a = 16'(16'h3800 | $urandom_range(0, 255));
        2: a = 16'($urandom);
        default: a = 16'(16'h3C00 + $urandom_range(0, 15));
      endcase
      rd_chk("R3 R4 R6 R7 rand", a, 1'($urandom_range(0, 4) != 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule